// File: doc/BRIEF.md
# Two-wire serial target with strap-selected address

This block is the receive and transmit front end of a two-wire serial target of the SMBus/I2C kind. It watches the clock line and the data line with the system clock. Each line passes through a synchronizer and a glitch filter. The block finds START and STOP conditions, takes in the address byte and answers only when the address matches its own. It then hands written bytes to a byte-wide register port, or it fetches bytes from that port and shifts them out on the bus.

The 7-bit target address is not held in a register or fixed in the logic. It comes from two strap inputs, each of which reads as low, high or open. The address is worked out from the straps while reset is asserted and then stays fixed until the next reset. A host on the bus always drives the clock. The block never stretches it.

The bus side is open drain. When `sda_oe` is high the pad must pull the data line low. When it is low the pad must release the line. The `sda_i` input must carry the resolved level of the line, including the block's own pull-down.

Top module: `strap_i2c_target`

## Requirements
- R1: Each strap is a 2-bit code: 00 means low, 01 means high, and 10 or 11 means open. With strap A on `strap_a` and strap B on `strap_b`, the address is as follows:
  - A low gives 0011000, 0011001 and 0011010 for B low, open and high.
  - A open gives 0101001, 0101010 and 0101011 for B low, open and high.
  - A high gives 1001100, 1001101 and 1001110 for B low, open and high.
- R2: The address is taken from the straps only while `rst` is high. Changing the straps after reset changes neither which address is acknowledged nor which is refused.
- R3: Until a START has been seen (data falling while clock is high), clocked bits get no acknowledge and produce no strobe.
- R4: The first byte after a START is read MSB first, with bits sampled while the clock is high. It holds the 7-bit address and then the direction bit (1 = read, 0 = write). On a match the target pulls data low for the whole high phase of the ninth clock.
- R5: On an address mismatch the target never drives data low and raises no strobe until the next START.
- R6: In a write transfer, each data byte is acknowledged in its ninth clock and appears on `wr_data` together with a `wr_valid` pulse that lasts exactly one cycle.
- R7: In a read transfer, the target pulses `rd_req` for one cycle. It takes `rd_data` in the following cycle and drives that byte MSB first on the next eight clocks, releasing data for 1 bits.
- R8: If the host acknowledges a read byte (data low in its ninth clock), the next byte is requested. If the host does not acknowledge it (data high), the target releases data and makes no further requests until the next STOP or START.
- R9: A repeated START at any point drops the partly received byte, produces no strobe for it, and starts address reception again.
- R10: After reset and after a STOP, `busy` is low and `sda_oe` is low. `busy` is high from an address match until STOP, START or a host non-acknowledge.
- R11: A pulse on either line that lasts shorter than the filter length is ignored. A one-cycle low pulse on the clock during a data bit adds no extra bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while high |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved) |
| strap_a | input | 2 | Strap A code: 00 low, 01 high, 1x open |
| strap_b | input | 2 | Strap B code: 00 low, 01 high, 1x open |
| sda_oe | output | 1 | 1 = pull data line low |
| busy | output | 1 | Target is addressed in the current transfer |
| xfer_read | output | 1 | Direction bit of the current transfer |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_data | output | 8 | Received write byte |
| rd_req | output | 1 | One-cycle request for the next read byte |
| rd_data | input | 8 | Read byte, valid in the cycle after `rd_req` |

## Verification
A wrong strap decode or a lost strap capture shows up at the ninth clock of the first address byte as a missing or unexpected acknowledge. A bit counter or shift register that slips by one shows up within the same byte: the written byte on `wr_data` comes out shifted, or the read byte on the bus does. A state machine that fails to leave its active state on a non-acknowledge, STOP or repeated START is seen on the next eight clocks, either as extra `rd_req` or `wr_valid` pulses or as data driven low when the line should be released.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_SET, ST_ACK_HOLD, ST_WR,
    ST_RD_LOAD, ST_RD_BIT, ST_RD_ACK, ST_RD_NEXT, ST_HOLD
  } tgt_state_e;

  // strap code: 00 low, 01 high, 1x open -> level 0 / 2 / 1
  function automatic logic [1:0] strap_level(input logic [1:0] code);
    if (code[1])      return 2'd1;
    else if (code[0]) return 2'd2;
    else              return 2'd0;
  endfunction

  function automatic logic [ADDR_W-1:0] strap_to_addr(input logic [1:0] a,
                                                      input logic [1:0] b);
    logic [1:0] la, lb;
    logic [3:0] upper;
    logic [2:0] base;
    la = strap_level(a);
    lb = strap_level(b);
    case (la)
      2'd0:    begin upper = 4'b0011; base = 3'd0; end
      2'd1:    begin upper = 4'b0101; base = 3'd1; end
      default: begin upper = 4'b1001; base = 3'd4; end
    endcase
    return {upper, base + {1'b0, lb}};
  endfunction
endpackage

// File: rtl/sbt_line_filter.sv
module sbt_line_filter #(
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_LEN-1:0] sync_q;
  logic [FILT_LEN-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
      if (&hist_q)       line_o <= 1'b1;
      else if (~|hist_q) line_o <= 1'b0;
    end
  end

  // R11: a filtered level never lasts a single cycle
  a_r11_min_hold: assert property (@(posedge clk) disable iff (rst)
    $changed(line_o) |=> $stable(line_o));
endmodule

// File: rtl/sbt_strap_addr.sv
module sbt_strap_addr
  import sbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        strap_a,
  input  logic [1:0]        strap_b,
  output logic [ADDR_W-1:0] dev_addr
);
  always_ff @(posedge clk) begin
    if (rst) dev_addr <= strap_to_addr(strap_a, strap_b);
  end

  // R2: address frozen outside reset
  a_r2_addr_held: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(dev_addr));
endmodule

// File: rtl/strap_i2c_target.sv
module strap_i2c_target
  import sbt_pkg::*;
#(
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        strap_a,
  input  logic [1:0]        strap_b,
  output logic              sda_oe,
  output logic              busy,
  output logic              xfer_read,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_req,
  input  logic [BYTE_W-1:0] rd_data
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [1:0] raw_lines, filt_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    sbt_line_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst(rst), .line_i(raw_lines[g]), .line_o(filt_lines[g]));
  end

  logic [ADDR_W-1:0] dev_addr;
  sbt_strap_addr u_strap (
    .clk(clk), .rst(rst), .strap_a(strap_a), .strap_b(strap_b),
    .dev_addr(dev_addr));

  logic scl_f, sda_f, scl_p, sda_p;
  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  logic start_det, stop_det, scl_rise, scl_fall;
  assign start_det = scl_f & scl_p &  sda_p & ~sda_f;
  assign stop_det  = scl_f & scl_p & ~sda_p &  sda_f;
  assign scl_rise  =  scl_f & ~scl_p;
  assign scl_fall  = ~scl_f &  scl_p;

  tgt_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      sda_oe    <= 1'b0;
      busy      <= 1'b0;
      xfer_read <= 1'b0;
      wr_valid  <= 1'b0;
      wr_data   <= '0;
      rd_req    <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      rd_req   <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
        busy    <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        busy   <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (scl_rise) begin
            shreg   <= {shreg[BYTE_W-3:0], sda_f};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              if (shreg == dev_addr) begin
                state     <= ST_ACK_SET;
                xfer_read <= sda_f;
                busy      <= 1'b1;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          ST_ACK_SET: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_ACK_HOLD;
          end
          ST_ACK_HOLD: if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            if (xfer_read) begin
              rd_req <= 1'b1;
              state  <= ST_RD_LOAD;
            end else begin
              state <= ST_WR;
            end
          end
          ST_WR: if (scl_rise) begin
            shreg   <= {shreg[BYTE_W-3:0], sda_f};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              wr_data  <= {shreg, sda_f};
              wr_valid <= 1'b1;
              state    <= ST_ACK_SET;
            end
          end
          ST_RD_LOAD: begin
            shreg   <= rd_data[BYTE_W-2:0];
            sda_oe  <= ~rd_data[BYTE_W-1];
            bit_cnt <= '0;
            state   <= ST_RD_BIT;
          end
          ST_RD_BIT: if (scl_fall) begin
            if (bit_cnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              state  <= ST_RD_ACK;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              sda_oe  <= ~shreg[BYTE_W-2];
              shreg   <= {shreg[BYTE_W-3:0], 1'b0};
            end
          end
          ST_RD_ACK: if (scl_rise) begin
            if (sda_f) begin
              state <= ST_HOLD;
              busy  <= 1'b0;
            end else begin
              state <= ST_RD_NEXT;
            end
          end
          ST_RD_NEXT: if (scl_fall) begin
            rd_req <= 1'b1;
            state  <= ST_RD_LOAD;
          end
          default: ;
        endcase
      end
    end
  end

  // R6: write strobe is a single cycle and only in write transfers
  a_r6_wr_single: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);
  a_r6_wr_dir: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> !xfer_read && busy);
  // R7 / R8: read request is a single cycle inside an addressed read
  a_r7_rd_dir: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> xfer_read && busy);
  a_r8_rd_single: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  // R5 / R10: an unaddressed target never pulls the data line
  a_r5_quiet_unaddressed: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sda_oe);
  // R9: START always restarts address reception with the line released
  a_r9_start_restart: assert property (@(posedge clk) disable iff (rst)
    start_det |=> state == ST_ADDR && !sda_oe && !busy);
endmodule

// File: tb/strap_i2c_target_bench.sv
module strap_i2c_target_bench;
  localparam int H = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap_a = 2'b00, strap_b = 2'b00;
  logic       sda_oe, busy, xfer_read, wr_valid, rd_req;
  logic [7:0] wr_data, rd_data;
  logic       sda_bus;
  int         tests = 0, fails = 0;
  int         wr_seen = 0, rd_cnt = 0;
  logic [7:0] wexp[$];

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  function automatic logic [7:0] rd_byte(input int n);
    return 8'h5A ^ 8'(n * 37);
  endfunction
  assign rd_data = rd_byte(rd_cnt);

  always @(posedge clk) if (!rst && rd_req) rd_cnt <= rd_cnt + 1;

  strap_i2c_target u_strap_i2c_target (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_a(strap_a), .strap_b(strap_b), .sda_oe(sda_oe), .busy(busy),
    .xfer_read(xfer_read), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .rd_data(rd_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for write strobes
  always @(negedge clk) begin
    if (!rst && wr_valid) begin
      wr_seen++;
      if (wexp.size() == 0) chk(1'b0, "R6 unexpected strobe", wr_data, 0);
      else begin
        logic [7:0] e;
        e = wexp.pop_front();
        chk(wr_data == e, "R6 write byte", wr_data, e);
      end
    end
  end

  function automatic logic [6:0] exp_addr(input logic [1:0] a, input logic [1:0] b);
    int la, lb;
    la = a[1] ? 1 : (a[0] ? 2 : 0);
    lb = b[1] ? 1 : (b[0] ? 2 : 0);
    case (la * 3 + lb)
      0: return 7'b0011000;  1: return 7'b0011001;  2: return 7'b0011010;
      3: return 7'b0101001;  4: return 7'b0101010;  5: return 7'b0101011;
      6: return 7'b1001100;  7: return 7'b1001101;  default: return 7'b1001110;
    endcase
  endfunction

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic do_reset(input logic [1:0] a, input logic [1:0] b);
    strap_a = a; strap_b = b; scl_m = 1; sda_m = 1;
    rst = 1; w(5); rst = 0; w(10);
  endtask

  task automatic bus_start;
    sda_m = 1; w(H); scl_m = 1; w(H); sda_m = 0; w(H); scl_m = 0; w(H);
  endtask
  task automatic bus_stop;
    sda_m = 0; w(H); scl_m = 1; w(H); sda_m = 1; w(H);
  endtask
  task automatic put_bit(input logic b, input bit glitch);
    sda_m = b; w(H); scl_m = 1;
    if (glitch) begin w(H/2); scl_m = 0; w(1); scl_m = 1; w(H/2 - 1); end
    else w(H);
    scl_m = 0;
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1; w(H); scl_m = 1; w(H/2); b = sda_bus; w(H/2); scl_m = 0;
  endtask
  task automatic put_byte(input logic [7:0] v, input bit glitch, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i], glitch && i == 3);
    get_bit(b);
    ack = ~b;
  endtask
  task automatic get_byte(input bit host_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      get_bit(b);
      v[i] = b;
    end
    put_bit(~host_ack, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] v;
    logic [6:0] ad;
    int ws, rc;
    logic [1:0] codes [3];
    codes[0] = 2'b00; codes[1] = 2'b10; codes[2] = 2'b01;

    do_reset(2'b00, 2'b00);
    chk(!sda_oe && !busy && !wr_valid && !rd_req, "R10 reset state",
        {sda_oe, busy, wr_valid, rd_req}, 0);

    // R1 / R4 / R5: every strap pair, matching and mismatching address
    for (int i = 0; i < 3; i++) begin
      for (int j = 0; j < 3; j++) begin
        do_reset(codes[i], codes[j]);
        ad = exp_addr(codes[i], codes[j]);
        bus_start; put_byte({ad, 1'b0}, 0, ack); bus_stop;
        chk(ack, "R1 strap address ack", ack, 1);
        bus_start; put_byte({ad ^ 7'h40, 1'b0}, 0, ack); bus_stop;
        chk(!ack, "R5 mismatch nack", ack, 0);
      end
    end

    // R2: straps changed after reset
    do_reset(2'b10, 2'b01);                 // 0101011
    strap_a = 2'b01; strap_b = 2'b00;      // would be 1001100
    w(5);
    bus_start; put_byte({7'b1001100, 1'b0}, 0, ack); bus_stop;
    chk(!ack, "R2 new strap address refused", ack, 0);
    bus_start; put_byte({7'b0101011, 1'b0}, 0, ack); bus_stop;
    chk(ack, "R2 reset address kept", ack, 1);

    // R3: bits without START
    scl_m = 0; w(H);
    put_byte({7'b0101011, 1'b0}, 0, ack);
    sda_m = 1; w(H); scl_m = 1; w(H);
    chk(!ack && !busy, "R3 no START no ack", {ack, busy}, 0);

    // R6 / R4 / R10: write transfer
    bus_start; put_byte({7'b0101011, 1'b0}, 0, ack);
    chk(ack && busy && !xfer_read, "R4 write address ack", {ack, busy, xfer_read}, 3'b110);
    foreach (v[k]) ;
    for (int k = 0; k < 3; k++) begin
      logic [7:0] d;
      d = 8'h81 + 8'(k * 8'h35);
      wexp.push_back(d);
      put_byte(d, 0, ack);
      chk(ack, "R6 write data ack", ack, 1);
    end
    bus_stop;
    chk(!busy && !sda_oe, "R10 idle after STOP", {busy, sda_oe}, 0);
    chk(wexp.size() == 0, "R6 all bytes strobed", wexp.size(), 0);

    // R11: clock glitch during a data bit
    bus_start; put_byte({7'b0101011, 1'b0}, 0, ack);
    wexp.push_back(8'hC3);
    put_byte(8'hC3, 1, ack);
    chk(ack, "R11 glitched byte ack", ack, 1);
    bus_stop;
    chk(wexp.size() == 0, "R11 glitched byte received once", wexp.size(), 0);

    // R7 / R8: read transfer, ACK then NACK
    rc = rd_cnt;
    bus_start; put_byte({7'b0101011, 1'b1}, 0, ack);
    chk(ack && xfer_read, "R7 read address ack", {ack, xfer_read}, 2'b11);
    get_byte(1, v);
    chk(v == rd_byte(rc), "R7 first read byte", v, rd_byte(rc));
    get_byte(0, v);
    chk(v == rd_byte(rc + 1), "R8 byte after host ACK", v, rd_byte(rc + 1));
    get_byte(0, v);
    chk(v == 8'hFF, "R8 released after NACK", v, 8'hFF);
    chk(rd_cnt == rc + 2 && !busy, "R8 no request after NACK", rd_cnt - rc, 2);
    bus_stop;

    // R9: repeated START in the middle of a write byte
    ws = wr_seen;
    rc = rd_cnt;
    bus_start; put_byte({7'b0101011, 1'b0}, 0, ack);
    for (int k = 0; k < 4; k++) put_bit(k[0], 0);
    bus_start; put_byte({7'b0101011, 1'b1}, 0, ack);
    chk(ack && xfer_read, "R9 restart address ack", {ack, xfer_read}, 2'b11);
    get_byte(0, v);
    chk(v == rd_byte(rc), "R9 read after restart", v, rd_byte(rc));
    bus_stop;
    chk(wr_seen == ws, "R9 partial byte dropped", wr_seen - ws, 0);

    // R5: data after mismatch
    ws = wr_seen;
    bus_start; put_byte({7'b0011000, 1'b0}, 0, ack);
    put_byte(8'h00, 0, ack);
    chk(!ack && wr_seen == ws, "R5 no ack or strobe after mismatch", {ack, wr_seen - ws}, 0);
    bus_stop;

    w(20);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule